// File: doc/BRIEF.md
# Pad Ownership Access Gate

This block guards the configuration storage of eight general-purpose pads. Each pad carries a two-bit owner code. Every register access that arrives on the slave port is checked against the owner of the pad it targets before it takes effect. A pad owned by host software accepts any requester. A pad owned by one of three management agents accepts only requests that carry that agent's source ID.

When a check fails, the outcome depends on the kind of request. A non-posted request receives an unsuccessful completion with zero data. A posted write is discarded and produces no completion. The owner codes are packed into one 32-bit word that every requester may read. Only agent A may write that word, and the secure-debug requester may also write it while debug mode is asserted. Each pad's configuration register is modelled as a 32-bit storage word inside the block. A one-hot write strobe marks every write that was allowed.

Top module: `pad_owner_gate`

## Requirements
- R1: After reset, every owner code is 00, every pad configuration word is zero and `cpl_valid` and `cfg_we` are low.
- R2: Address 0 holds the owner word, and address n+1 holds pad n's configuration word. In the owner word, pad n's code sits at bits [4n+1:4n]. All other bits read as zero, and writes to them have no effect.
- R3: Only source ID `SRC_A` may write the owner word. A write from any other source leaves the word unchanged, and a non-posted one completes unsuccessfully. Reads of the owner word succeed from any source.
- R4: While `dbg_mode` is high, source ID `SRC_DBG` may also write the owner word. While `dbg_mode` is low, its writes are rejected.
- R5: A pad with owner code 00 (host) accepts reads and writes of its configuration word from any source ID.
- R6: A pad with owner code 01, 10 or 11 accepts configuration accesses only from `SRC_A`, `SRC_B` or `SRC_C` respectively.
- R7: Every non-posted request (any read, or a write with `req_posted` low) gets exactly one `cpl_valid` pulse in the cycle after it is accepted. A failed request gives `cpl_ok`=0 and `cpl_rdata`=0. An allowed read returns the addressed word, and an allowed write returns zero data.
- R8: A posted write never raises `cpl_valid`. If its check fails, the targeted storage is left unchanged.
- R9: An allowed write to pad n's configuration word raises only bit n of `cfg_we`, for one cycle, in the cycle after the request. The new data is readable from that cycle onward.
- R10: An owner code whose bit is clear in the parameter `CODE_VALID` acts as host ownership (00) for the access check. The stored code still reads back unchanged.
- R11: A request to an address above `NPADS` fails. A non-posted one completes unsuccessfully, and a write to such an address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dbg_mode | input | 1 | Debug mode; enables owner writes from the debug source |
| req_valid | input | 1 | Request present this cycle (always accepted) |
| req_addr | input | ADDR_W | Register address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_posted | input | 1 | 1 = posted write (no completion) |
| req_src | input | SRC_W | Requester source ID |
| req_wdata | input | 32 | Write data |
| cpl_valid | output | 1 | Completion present |
| cpl_ok | output | 1 | Completion status, 1 = success |
| cpl_rdata | output | 32 | Completion read data |
| cfg_we | output | NPADS | One-hot strobe for an allowed pad configuration write |

## Verification
Every result is registered, so the completion, the write strobe and the storage update all appear in the cycle after the request edge. A read issued in the following cycle returns the new contents. The bench drives each request on a falling edge, removes it on the next falling edge and samples all outputs at that moment. That is half a cycle after the single register stage, so exactly the request's own result is seen. The sweep covers every pad, owner code, source and access kind. After each access a separate read-back, issued as the owner, confirms whether storage changed. A posted write is confirmed only through that read-back and the strobe, since it has no completion.

// File: rtl/pad_owner_gate.sv
module pad_owner_gate #(
  parameter int NPADS = 8,
  parameter int SRC_W = 8,
  parameter int ADDR_W = 4,
  parameter logic [SRC_W-1:0] SRC_A = 8'h21,
  parameter logic [SRC_W-1:0] SRC_B = 8'h4E,
  parameter logic [SRC_W-1:0] SRC_C = 8'h63,
  parameter logic [SRC_W-1:0] SRC_DBG = 8'h7F,
  parameter logic [3:0] CODE_VALID = 4'b1111
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbg_mode,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_posted,
  input  logic [SRC_W-1:0]  req_src,
  input  logic [31:0]       req_wdata,
  output logic              cpl_valid,
  output logic              cpl_ok,
  output logic [31:0]       cpl_rdata,
  output logic [NPADS-1:0]  cfg_we
);
  localparam int PW = (NPADS > 1) ? $clog2(NPADS) : 1;

  logic [1:0]  own_q [NPADS];
  logic [31:0] cfg_q [NPADS];
  logic [31:0] own_word;

  always_comb begin
    own_word = '0;
    for (int i = 0; i < NPADS; i++) own_word[4*i +: 2] = own_q[i];
  end

  wire              hit_own = (req_addr == '0);
  wire              hit_pad = (req_addr >= 1) && (int'(req_addr) <= NPADS);
  wire [ADDR_W-1:0] pad_off = req_addr - 1'b1;
  wire [PW-1:0]     pad_idx = pad_off[PW-1:0];
  wire              posted  = req_write && req_posted;
  wire              own_wr_ok = (req_src == SRC_A) || (dbg_mode && req_src == SRC_DBG);

  logic [1:0]       code, eff;
  logic [SRC_W-1:0] owner_src;

  always_comb begin
    code = hit_pad ? own_q[pad_idx] : 2'b00;
    eff  = CODE_VALID[code] ? code : 2'b00;
    case (eff)
      2'b01:   owner_src = SRC_A;
      2'b10:   owner_src = SRC_B;
      2'b11:   owner_src = SRC_C;
      default: owner_src = '0;
    endcase
  end

  wire pad_pass = (eff == 2'b00) || (req_src == owner_src);
  wire pass = hit_own ? (!req_write || own_wr_ok) : (hit_pad && pad_pass);
  wire [31:0] rd_sel = hit_own ? own_word : (hit_pad ? cfg_q[pad_idx] : 32'h0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NPADS; i++) begin
        own_q[i] <= 2'b00;
        cfg_q[i] <= '0;
      end
      cpl_valid <= 1'b0;
      cpl_ok    <= 1'b0;
      cpl_rdata <= '0;
      cfg_we    <= '0;
    end else begin
      cpl_valid <= req_valid && !posted;
      cpl_ok    <= req_valid && pass;
      cpl_rdata <= (req_valid && pass && !req_write) ? rd_sel : 32'h0;
      cfg_we    <= '0;
      if (req_valid && req_write && pass) begin
        if (hit_own) begin
          for (int i = 0; i < NPADS; i++) own_q[i] <= req_wdata[4*i +: 2];
        end else begin
          cfg_q[pad_idx]  <= req_wdata;
          cfg_we[pad_idx] <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pad_owner_gate_chk.sv
module pad_owner_gate_chk #(
  parameter int NPADS = 8,
  parameter int SRC_W = 8,
  parameter int ADDR_W = 4,
  parameter logic [SRC_W-1:0] SRC_A = 8'h21,
  parameter logic [SRC_W-1:0] SRC_DBG = 8'h7F
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dbg_mode,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_write,
  input logic              req_posted,
  input logic [SRC_W-1:0]  req_src,
  input logic              cpl_valid,
  input logic              cpl_ok,
  input logic [31:0]       cpl_rdata,
  input logic [NPADS-1:0]  cfg_we,
  input logic [31:0]       own_word
);
  wire bad_own_wr = req_valid && req_write && (req_addr == '0) &&
                    !(req_src == SRC_A || (dbg_mode && req_src == SRC_DBG));

  a_r3_owner_word_guarded: assert property (@(posedge clk) disable iff (!rst_n)
    bad_own_wr |=> $stable(own_word));

  a_r7_nonposted_completes: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !(req_write && req_posted)) |=> cpl_valid);

  a_r7_fail_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && !cpl_ok) |-> (cpl_rdata == 32'h0));

  a_r8_posted_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_posted) |=> !cpl_valid);

  a_r9_strobe_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cfg_we));

  a_r9_strobe_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write) |=> (cfg_we == '0));

  a_r11_unmapped_fails: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && int'(req_addr) > NPADS) |=> !cpl_ok);
endmodule

bind pad_owner_gate pad_owner_gate_chk #(
  .NPADS(NPADS), .SRC_W(SRC_W), .ADDR_W(ADDR_W), .SRC_A(SRC_A), .SRC_DBG(SRC_DBG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .dbg_mode(dbg_mode), .req_valid(req_valid),
  .req_addr(req_addr), .req_write(req_write), .req_posted(req_posted),
  .req_src(req_src), .cpl_valid(cpl_valid), .cpl_ok(cpl_ok),
  .cpl_rdata(cpl_rdata), .cfg_we(cfg_we), .own_word(own_word)
);

// File: tb/tb_pad_owner_gate.sv
module tb_pad_owner_gate;
  localparam logic [7:0] S_H = 8'h05, S_A = 8'h21, S_B = 8'h4E, S_C = 8'h63, S_D = 8'h7F;

  logic clk = 1'b0, rst_n = 1'b0, dbg = 1'b0;
  logic rv = 1'b0, rw = 1'b0, rp = 1'b0;
  logic [3:0] ra = '0;
  logic [7:0] rs = '0;
  logic [31:0] wd = '0;
  logic cv, ck, cv2, ck2;
  logic [31:0] crd, crd2;
  logic [7:0] cwe, cwe2;
  logic o_cv, o_ck, o2_ck;
  logic [31:0] o_rd, o2_rd;
  logic [7:0] o_we;
  int checks = 0, fails = 0;
  logic [1:0] m_own [8];
  logic [31:0] m_cfg [8];

  always #10 clk = ~clk;

  pad_owner_gate dut (.clk(clk), .rst_n(rst_n), .dbg_mode(dbg), .req_valid(rv),
    .req_addr(ra), .req_write(rw), .req_posted(rp), .req_src(rs), .req_wdata(wd),
    .cpl_valid(cv), .cpl_ok(ck), .cpl_rdata(crd), .cfg_we(cwe));

  pad_owner_gate #(.CODE_VALID(4'b0111)) dut_r (.clk(clk), .rst_n(rst_n), .dbg_mode(dbg),
    .req_valid(rv), .req_addr(ra), .req_write(rw), .req_posted(rp), .req_src(rs),
    .req_wdata(wd), .cpl_valid(cv2), .cpl_ok(ck2), .cpl_rdata(crd2), .cfg_we(cwe2));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic req(input logic [3:0] a, input logic w, input logic p,
                     input logic [7:0] s, input logic [31:0] d);
    @(negedge clk);
    ra = a; rw = w; rp = p; rs = s; wd = d; rv = 1'b1;
    @(negedge clk);
    rv = 1'b0;
    o_cv = cv; o_ck = ck; o_rd = crd; o_we = cwe; o2_ck = ck2; o2_rd = crd2;
  endtask

  function automatic logic [7:0] src_of(input logic [1:0] c);
    case (c)
      2'b01: return S_A;
      2'b10: return S_B;
      2'b11: return S_C;
      default: return S_H;
    endcase
  endfunction

  function automatic logic [31:0] packed_own();
    logic [31:0] v = '0;
    for (int i = 0; i < 8; i++) v[4*i +: 2] = m_own[i];
    return v;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] srcs [5];
    srcs[0] = S_H; srcs[1] = S_A; srcs[2] = S_B; srcs[3] = S_C; srcs[4] = S_D;
    for (int i = 0; i < 8; i++) begin m_own[i] = 2'b00; m_cfg[i] = '0; end
    repeat (3) @(negedge clk);
    check("R1 cpl_valid after reset", {31'b0, cv}, 32'h0);
    check("R1 cfg_we after reset", {24'b0, cwe}, 32'h0);
    rst_n = 1'b1;
    req(4'd0, 1'b0, 1'b0, S_H, 0);
    check("R1 owner word reset", o_rd, 32'h0);
    req(4'd5, 1'b0, 1'b0, S_B, 0);
    check("R1 cfg word reset", o_rd, 32'h0);

    req(4'd0, 1'b1, 1'b0, S_A, 32'hFFFF_FFFF);
    check("R2 owner write ok", {31'b0, o_ck}, 32'h1);
    req(4'd0, 1'b0, 1'b0, S_C, 0);
    check("R2 reserved bits read zero", o_rd, 32'h3333_3333);
    check("R3 any source reads owner", {31'b0, o_ck}, 32'h1);
    req(4'd0, 1'b1, 1'b0, S_B, 32'h0);
    check("R3 foreign owner write fails", {o_cv, o_ck}, 32'h2);
    req(4'd0, 1'b1, 1'b1, S_H, 32'h0);
    req(4'd0, 1'b0, 1'b0, S_H, 0);
    check("R3 rejected writes leave owner", o_rd, 32'h3333_3333);
    req(4'd0, 1'b1, 1'b0, S_D, 32'h0);
    check("R4 debug write w/o mode fails", {31'b0, o_ck}, 32'h0);
    dbg = 1'b1;
    req(4'd0, 1'b1, 1'b0, S_D, 32'h0000_0012);
    check("R4 debug write with mode ok", {31'b0, o_ck}, 32'h1);
    dbg = 1'b0;
    req(4'd0, 1'b0, 1'b0, S_H, 0);
    check("R4 debug-written owner word", o_rd, 32'h0000_0012);

    req(4'd0, 1'b1, 1'b0, S_A, 32'h3000_0000);
    req(4'd8, 1'b1, 1'b0, S_H, 32'hCAFE_0007);
    check("R10 disabled code acts as host (write)", {31'b0, o2_ck}, 32'h1);
    req(4'd8, 1'b0, 1'b0, S_H, 0);
    check("R10 disabled code read data", o2_rd, 32'hCAFE_0007);
    check("R6 code 11 blocks host on default build", {31'b0, o_ck}, 32'h0);
    req(4'd0, 1'b0, 1'b0, S_H, 0);
    check("R10 stored code reads back", o2_rd, 32'h3000_0000);
    req(4'd0, 1'b1, 1'b0, S_A, 32'h0);

    for (int a = 9; a < 16; a++) begin
      req(4'(a), 1'b1, 1'b0, S_A, 32'h1234_5678);
      check("R11 unmapped write fails", {o_cv, o_ck}, 32'h2);
      check("R11 unmapped write no strobe", {24'b0, o_we}, 32'h0);
      req(4'(a), 1'b0, 1'b0, S_H, 0);
      check("R11 unmapped read fails", {o_cv, o_ck}, 32'h2);
    end

    for (int p = 0; p < 8; p++)
      for (int c = 0; c < 4; c++)
        for (int si = 0; si < 5; si++)
          for (int k = 0; k < 3; k++) begin
            logic ok;
            logic [31:0] d;
            m_own[p] = 2'(c);
            req(4'd0, 1'b1, 1'b0, S_A, packed_own());
            check("R3 owner set", {31'b0, o_ck}, 32'h1);
            ok = (c == 0) || (srcs[si] == src_of(2'(c)));
            d = 32'h5A00_0000 ^ 32'(p * 4096 + c * 256 + si * 16 + k);
            req(4'(p + 1), k != 0, k == 2, srcs[si], d);
            if (k == 2) check("R8 posted no completion", {31'b0, o_cv}, 32'h0);
            else begin
              check(c == 0 ? "R5 np completion" : "R6 np completion",
                    {o_cv, o_ck}, {30'b0, 1'b1, ok});
              check("R7 completion data", o_rd, (k == 0 && ok) ? m_cfg[p] : 32'h0);
            end
            check("R9 write strobe", {24'b0, o_we}, (k != 0 && ok) ? 32'(1 << p) : 32'h0);
            if (k != 0 && ok) m_cfg[p] = d;
            req(4'(p + 1), 1'b0, 1'b0, src_of(2'(c)), 0);
            check("R8 R9 storage after access", o_rd, m_cfg[p]);
          end

    req(4'd0, 1'b0, 1'b0, S_B, 0);
    check("R2 final owner word", o_rd, packed_own());

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule